// File: doc/BRIEF.md
# Drive Type Probe and Identify Fetch Sequencer

This block runs on the host side of a disk interface. After a start pulse it works out whether the attached drive is a plain ATA disk or a packet-command (ATAPI) device, and it fetches the drive's 256-word identify data. It does all of this through a request/acknowledge port to a task-file register engine. Each access carries a 3-bit register address, a write flag and 16 bits of write data, and the engine returns 16 bits of read data with a one-cycle acknowledge.

The sequencer first polls status until the drive reports ready, then issues the ATA identify opcode 0xEC. A packet device rejects that opcode on purpose. The sequencer treats that rejection as a probe result and reads four signature bytes. If they match the packet pattern, it issues the packet identify opcode 0xA1 at once, without waiting for ready. In both cases it waits for the data-request flag, then streams the identify words out by programmed reads of the data register. It also reports whether the packet device expects 12-byte or 16-byte command packets.

Top module: `ata_ident_seq`

## Requirements
- R1: After reset, dev_type is 0 (unknown), done, err and word_valid are 0, and no register request is raised.
- R2: Opcode 0xEC is written to the command register (address 7) only after a status read that shows bit 7 (busy) clear and bit 6 (ready) set.
- R3: Whenever status bit 7 (busy) is set, all other status bits are ignored. Such a read counts as neither ready, data request, error nor fault.
- R4: The first status read after each command write is discarded unexamined.
- R5: If data request (status bit 3) follows 0xEC, dev_type becomes 1 (ATA). The sequencer then reads address 0 exactly 256 times and presents each word on word, in order, with a word_valid pulse. done pulses one cycle after the last word.
- R6: If an abort (busy clear with bit 0 error or bit 5 fault set) follows 0xEC, the sequencer reads the signature registers in this order: sector count (address 2), LBA low (3), LBA mid (4), LBA high (5).
- R7: A signature of 0x01, 0x01, 0x14, 0xEB, in the R6 order, sets dev_type to 2 (packet). The very next access is a write of 0xA1 to address 7, with no status poll in between.
- R8: Any other signature sets err to 1 and dev_type to 0, and 0xA1 is never issued.
- R9: After 0xA1 the sequencer waits for data request, then streams 256 words and pulses done, as in R5.
- R10: pkt16 is 1 exactly when the device is a packet device and bits [1:0] of identify word 0 are 01 (16-byte packets). For 00 (12-byte packets), and for ATA disks, pkt16 is 0.
- R11: With POLL_LIMIT consecutive not-satisfied status reads already counted, the next such read sets err to 1 and dev_type to 0.
- R12: A raised request holds its address, write flag and write data unchanged until the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a probe when idle; clears err, dev_type and pkt16 |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 3 | Task-file register address |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid with reg_ack |
| reg_ack | input | 1 | One-cycle access completion |
| dev_type | output | 2 | 0 unknown, 1 ATA, 2 packet |
| pkt16 | output | 1 | Packet device uses 16-byte command packets |
| word_valid | output | 1 | Identify word strobe |
| word | output | 16 | Identify word |
| done | output | 1 | One-cycle pulse after the last word |
| err | output | 1 | Probe failed; held until next start |

## Verification
If the phase register is wrong, the bus shows it within one access. A wrong phase lets a busy or discarded status read through, so the drive is classified too early or wrongly aborted, and the command sequence visible on the register port diverges right there. A mis-stored signature byte or an off-by-one word counter shows up at the end of the run: the wrong device type or an error flag on a valid drive, or a word stream that is one word short or long before done.

// File: rtl/ata_ident_pkg.sv
package ata_ident_pkg;

    localparam logic [2:0] A_DATA    = 3'd0;
    localparam logic [2:0] A_SECCNT  = 3'd2;
    localparam logic [2:0] A_LBAHI   = 3'd5;
    localparam logic [2:0] A_STATCMD = 3'd7;

    localparam logic [7:0] OP_ID_ATA = 8'hEC;
    localparam logic [7:0] OP_ID_PKT = 8'hA1;

    localparam int B_BSY = 7;
    localparam int B_RDY = 6;
    localparam int B_DF  = 5;
    localparam int B_DRQ = 3;
    localparam int B_ERR = 0;

    // sector count in the top byte, LBA high in the bottom byte
    localparam logic [31:0] PKT_SIG = {8'h01, 8'h01, 8'h14, 8'hEB};

    typedef enum logic [1:0] {DEV_NONE = 2'd0, DEV_ATA = 2'd1, DEV_PKT = 2'd2} dev_e;
    typedef enum logic [1:0] {V_WAIT, V_OK, V_FAIL} verdict_e;
    typedef enum logic [1:0] {PH_RDY, PH_DRQ_ATA, PH_DRQ_PKT} phase_e;
    typedef enum logic [2:0] {
        S_IDLE, S_POLL, S_CMD, S_SIG, S_CHK, S_DATA, S_FIN, S_FAIL
    } st_e;

endpackage

// File: rtl/ata_status_eval.sv
module ata_status_eval
    import ata_ident_pkg::*;
(
    input  logic [7:0] status,
    input  logic [7:0] mask,
    output verdict_e   verdict
);
    always_comb begin
        if (status[B_BSY]) begin
            verdict = V_WAIT;              // busy hides every other bit
        end else if (status[B_ERR] || status[B_DF]) begin
            verdict = V_FAIL;
        end else if ((status & mask) != 8'h00) begin
            verdict = V_OK;
        end else begin
            verdict = V_WAIT;
        end
    end
endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int PW = $clog2(LIMIT + 1);
    localparam logic [PW-1:0] TOP = PW'(LIMIT);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == TOP);

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && !clear) |=> (cnt_q == TOP));
endmodule

// File: rtl/ata_sig_match.sv
module ata_sig_match
    import ata_ident_pkg::*;
(
    input  logic [31:0] bytes_in,
    output logic        match
);
    logic [3:0] byte_eq;
    for (genvar i = 0; i < 4; i++) begin : g_byte
        assign byte_eq[i] = (bytes_in[8*i +: 8] == PKT_SIG[8*i +: 8]);
    end
    assign match = &byte_eq;
endmodule

// File: rtl/ata_ident_seq.sv
module ata_ident_seq
    import ata_ident_pkg::*;
#(
    parameter int WORDS      = 256,
    parameter int POLL_LIMIT = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        reg_req,
    output logic        reg_we,
    output logic [2:0]  reg_addr,
    output logic [15:0] reg_wdata,
    input  logic [15:0] reg_rdata,
    input  logic        reg_ack,
    output logic [1:0]  dev_type,
    output logic        pkt16,
    output logic        word_valid,
    output logic [15:0] word,
    output logic        done,
    output logic        err
);
    localparam int CW = $clog2(WORDS);
    localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

    typedef struct packed {
        st_e          st;
        phase_e       ph;
        logic         req;
        logic         we;
        logic [2:0]   addr;
        logic [15:0]  wdata;
        logic         skip;
        logic [1:0]   sig_idx;
        logic [31:0]  sig;
        logic [CW-1:0] wcnt;
        logic         wvld;
        logic [15:0]  word;
        logic         done;
        logic         err;
        dev_e         dev;
        logic         pkt16;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    verdict_e verdict;
    logic     tmr_clr, tmr_tick, tmr_exp;
    logic     sig_ok;
    logic [7:0] wait_mask;

    assign wait_mask = (ctl_q.ph == PH_RDY) ? 8'(1 << B_RDY) : 8'(1 << B_DRQ);

    ata_status_eval u_eval (
        .status  (reg_rdata[7:0]),
        .mask    (wait_mask),
        .verdict (verdict)
    );

    ata_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clr),
        .tick    (tmr_tick),
        .expired (tmr_exp)
    );

    ata_sig_match u_sig (
        .bytes_in (ctl_q.sig),
        .match    (sig_ok)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.wvld = 1'b0;
        ctl_d.done = 1'b0;
        tmr_clr    = 1'b0;
        tmr_tick   = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.err   = 1'b0;
                    ctl_d.dev   = DEV_NONE;
                    ctl_d.pkt16 = 1'b0;
                    ctl_d.ph    = PH_RDY;
                    ctl_d.skip  = 1'b0;
                    ctl_d.req   = 1'b1;
                    ctl_d.we    = 1'b0;
                    ctl_d.addr  = A_STATCMD;
                    ctl_d.st    = S_POLL;
                    tmr_clr     = 1'b1;
                end
            end
            S_POLL: begin
                if (reg_ack) begin
                    if (ctl_q.skip) begin
                        ctl_d.skip = 1'b0;      // settle read, contents unused
                    end else begin
                        case (verdict)
                            V_WAIT: begin
                                if (tmr_exp) begin
                                    ctl_d.req = 1'b0;
                                    ctl_d.st  = S_FAIL;
                                end else begin
                                    tmr_tick = 1'b1;
                                end
                            end
                            V_OK: begin
                                case (ctl_q.ph)
                                    PH_RDY: begin
                                        ctl_d.st    = S_CMD;
                                        ctl_d.we    = 1'b1;
                                        ctl_d.wdata = {8'h00, OP_ID_ATA};
                                        ctl_d.ph    = PH_DRQ_ATA;
                                    end
                                    PH_DRQ_ATA: begin
                                        ctl_d.dev  = DEV_ATA;
                                        ctl_d.st   = S_DATA;
                                        ctl_d.addr = A_DATA;
                                        ctl_d.wcnt = '0;
                                    end
                                    default: begin
                                        ctl_d.st   = S_DATA;
                                        ctl_d.addr = A_DATA;
                                        ctl_d.wcnt = '0;
                                    end
                                endcase
                            end
                            default: begin
                                if (ctl_q.ph == PH_DRQ_ATA) begin
                                    ctl_d.st      = S_SIG;
                                    ctl_d.addr    = A_SECCNT;
                                    ctl_d.sig_idx = 2'd0;
                                end else begin
                                    ctl_d.req = 1'b0;
                                    ctl_d.st  = S_FAIL;
                                end
                            end
                        endcase
                    end
                end
            end
            S_CMD: begin
                if (reg_ack) begin
                    ctl_d.we   = 1'b0;
                    ctl_d.addr = A_STATCMD;
                    ctl_d.skip = 1'b1;
                    ctl_d.st   = S_POLL;
                    tmr_clr    = 1'b1;
                end
            end
            S_SIG: begin
                if (reg_ack) begin
                    ctl_d.sig = {ctl_q.sig[23:0], reg_rdata[7:0]};
                    if (ctl_q.sig_idx == 2'd3) begin
                        ctl_d.req = 1'b0;
                        ctl_d.st  = S_CHK;
                    end else begin
                        ctl_d.sig_idx = ctl_q.sig_idx + 2'd1;
                        ctl_d.addr    = ctl_q.addr + 3'd1;
                    end
                end
            end
            S_CHK: begin
                if (sig_ok) begin
                    ctl_d.dev   = DEV_PKT;
                    ctl_d.req   = 1'b1;
                    ctl_d.we    = 1'b1;
                    ctl_d.addr  = A_STATCMD;
                    ctl_d.wdata = {8'h00, OP_ID_PKT};
                    ctl_d.ph    = PH_DRQ_PKT;
                    ctl_d.st    = S_CMD;
                end else begin
                    ctl_d.st = S_FAIL;
                end
            end
            S_DATA: begin
                if (reg_ack) begin
                    ctl_d.wvld = 1'b1;
                    ctl_d.word = reg_rdata;
                    if (ctl_q.wcnt == '0 && ctl_q.dev == DEV_PKT) begin
                        ctl_d.pkt16 = (reg_rdata[1:0] == 2'b01);
                    end
                    if (ctl_q.wcnt == LAST) begin
                        ctl_d.req = 1'b0;
                        ctl_d.st  = S_FIN;
                    end else begin
                        ctl_d.wcnt = ctl_q.wcnt + 1'b1;
                    end
                end
            end
            S_FIN: begin
                ctl_d.done = 1'b1;
                ctl_d.st   = S_IDLE;
            end
            default: begin
                ctl_d.err = 1'b1;
                ctl_d.dev = DEV_NONE;
                ctl_d.req = 1'b0;
                ctl_d.st  = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, ph: PH_RDY, dev: DEV_NONE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign reg_req    = ctl_q.req;
    assign reg_we     = ctl_q.we;
    assign reg_addr   = ctl_q.addr;
    assign reg_wdata  = ctl_q.wdata;
    assign dev_type   = ctl_q.dev;
    assign pkt16      = ctl_q.pkt16;
    assign word_valid = ctl_q.wvld;
    assign word       = ctl_q.word;
    assign done       = ctl_q.done;
    assign err        = ctl_q.err;

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we)
                                   && $stable(reg_wdata)));

    a_r5_word_from_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(reg_req && reg_ack && !reg_we && reg_addr == A_DATA));

    a_r9_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(word_valid) && dev_type != DEV_NONE && !err));

    a_r7_pkt_cmd_needs_sig: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_wdata[7:0] == OP_ID_PKT) |-> (dev_type == DEV_PKT));

    a_r8_err_clears_type: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (dev_type == DEV_NONE));

    a_r10_pkt16_only_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        pkt16 |-> (dev_type == DEV_PKT));
endmodule

// File: tb/tb_ata_ident_seq.sv
module tb_ata_ident_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20;
    localparam int NWORDS     = 256;

    localparam int M_ATA = 1, M_PKT12 = 2, M_PKT16 = 3, M_BADSIG = 4, M_TMO = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        reg_req, reg_we;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata = '0;
    logic        reg_ack = 1'b0;
    logic [1:0]  dev_type;
    logic        pkt16, word_valid, done, err;
    logic [15:0] word;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_ident_seq #(.WORDS(NWORDS), .POLL_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
        .dev_type(dev_type), .pkt16(pkt16), .word_valid(word_valid),
        .word(word), .done(done), .err(err)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int m, input int i);
        if (i == 0) begin
            if (m == M_PKT16) return 16'h8581;
            if (m == M_PKT12) return 16'h8580;
            return 16'h0040;
        end
        return 16'((m << 12) ^ (i * 7) ^ 16'h0A50);
    endfunction

    // device model state
    int         mode = 0;
    int         st_reads, total_stat, cmd_cnt, sig_pos, data_idx;
    bit         rdy_told, saw_a1, prev_we;
    int         prev_addr;
    logic [7:0] last_cmd;
    logic [15:0] sb_q[$];

    task automatic model_clear();
        st_reads = 0; total_stat = 0; cmd_cnt = 0; sig_pos = 0; data_idx = 0;
        rdy_told = 0; saw_a1 = 0; prev_we = 0; prev_addr = -1; last_cmd = 8'h00;
        sb_q.delete();
    endtask

    function automatic logic [7:0] stat_resp();
        if (mode == M_TMO) return 8'h00;
        if (cmd_cnt == 0) begin
            if (st_reads < 3)  return 8'hC9;   // busy plus garbage bits (R3)
            if (st_reads == 3) return 8'h00;
            return 8'h40;
        end
        if (st_reads == 0) return 8'h01;       // must be discarded (R4)
        if (st_reads < 3)  return 8'h89;       // busy plus garbage bits
        if (last_cmd == 8'hEC) begin
            if (mode == M_ATA) return 8'h48;
            return 8'h41;                      // abort
        end
        return 8'h08;
    endfunction

    // device model: responds at negedge, one access at a time
    always @(negedge clk) begin
        if (reg_ack) begin
            reg_ack <= 1'b0;
        end else if (rst_n && reg_req) begin
            logic [15:0] rd;
            rd = 16'h0000;
            if (reg_we) begin
                if (reg_addr == 3'd7) begin
                    if (reg_wdata[7:0] == 8'hEC) begin
                        chk(rdy_told, "R2 ready seen before 0xEC", rdy_told, 1);
                        chk(cmd_cnt == 0, "R3 0xEC issued once after busy reads", cmd_cnt, 0);
                    end else if (reg_wdata[7:0] == 8'hA1) begin
                        saw_a1 = 1;
                        chk(!prev_we && prev_addr == 5, "R7 0xA1 follows LBA high read",
                            prev_addr, 5);
                    end else begin
                        chk(0, "R2 unexpected command", reg_wdata, 8'hEC);
                    end
                    cmd_cnt++;
                    last_cmd = reg_wdata[7:0];
                    st_reads = 0;
                end else begin
                    chk(0, "R12 unexpected write address", reg_addr, 7);
                end
            end else begin
                case (reg_addr)
                    3'd7: begin
                        rd = {8'h00, stat_resp()};
                        if (rd[7:0] == 8'h40) rdy_told = 1;
                        st_reads++;
                        total_stat++;
                    end
                    3'd2, 3'd3, 3'd4, 3'd5: begin
                        chk(reg_addr == 3'(2 + sig_pos), "R6 signature read order",
                            reg_addr, 2 + sig_pos);
                        sig_pos++;
                        case (reg_addr)
                            3'd2, 3'd3: rd = 16'h0001;
                            3'd4:       rd = 16'h0014;
                            default:    rd = (mode == M_BADSIG) ? 16'h00EA : 16'h00EB;
                        endcase
                    end
                    3'd0: begin
                        rd = exp_word(mode, data_idx);
                        sb_q.push_back(rd);
                        data_idx++;
                    end
                    default: chk(0, "R12 unexpected read address", reg_addr, 0);
                endcase
            end
            prev_we   = reg_we;
            prev_addr = int'(reg_addr);
            reg_rdata <= rd;
            reg_ack   <= 1'b1;
        end
    end

    // scoreboard monitor
    int words_seen = 0;
    bit prev_wv = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R5 word without data read", word, 0);
                end else begin
                    logic [15:0] e;
                    e = sb_q.pop_front();
                    chk(word == e, "R5/R9 identify word", word, e);
                end
                words_seen++;
            end
            if (done) begin
                chk(prev_wv, "R5 done one cycle after last word", prev_wv, 1);
                chk(words_seen == NWORDS, "R9 word count at done", words_seen, NWORDS);
            end
        end
        prev_wv = word_valid;
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic run_mode(input int m, input int exp_dev, input bit exp_err,
                            input bit exp_p16);
        int w;
        @(negedge clk);
        model_clear();
        words_seen = 0;
        mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && !err && w < 5000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        chk(dev_type == 2'(exp_dev), $sformatf("R5/R7/R8 dev_type mode %0d", m),
            dev_type, exp_dev);
        chk(err == exp_err, $sformatf("R8/R11 err mode %0d", m), err, exp_err);
        chk(pkt16 == exp_p16, $sformatf("R10 pkt16 mode %0d", m), pkt16, exp_p16);
        chk(words_seen == (exp_err ? 0 : NWORDS), $sformatf("R5 words mode %0d", m),
            words_seen, exp_err ? 0 : NWORDS);
        chk(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        chk(dev_type == 2'd0 && !done && !err && !word_valid && !reg_req,
            "R1 reset outputs", {dev_type, done, err, word_valid, reg_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!reg_req, "R1 idle without start", reg_req, 0);

        run_mode(M_PKT16, 2, 0, 1);
        chk(saw_a1 && cmd_cnt == 2, "R7 packet identify issued", cmd_cnt, 2);
        chk(sig_pos == 4, "R6 four signature reads", sig_pos, 4);

        run_mode(M_ATA, 1, 0, 0);
        chk(cmd_cnt == 1 && sig_pos == 0, "R4 settle read ignored, no abort", sig_pos, 0);

        run_mode(M_PKT12, 2, 0, 0);

        run_mode(M_BADSIG, 0, 1, 0);
        chk(!saw_a1, "R8 no 0xA1 after bad signature", saw_a1, 0);

        run_mode(M_TMO, 0, 1, 0);
        chk(total_stat == LIMIT + 1, "R11 status reads before timeout",
            total_stat, LIMIT + 1);
        chk(cmd_cnt == 0, "R11 no command without ready", cmd_cnt, 0);

        run_mode(M_ATA, 1, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule